// File: doc/BRIEF.md
# Repartitionable Direct-Mapped Cache Controller

This block sits between a processor core and an external bus. It holds a single store of lines, each four 32-bit words long, and serves core reads from it in one cycle when the line is present. The store can cache only instruction fetches, only data accesses, or both at once. In the shared case it splits into two equal halves, one for instructions and one for data. A read miss fetches the whole line from the bus as a wrapping burst, starting at the requested word. The words collect in a line buffer, and the line goes into the store only when the last word has arrived. Every write goes out to the bus. A write that hits a cached data line also refreshes the stored word.

The core presents a request and holds it stable until `req_ready` is high. A read hit completes in the cycle it is presented. A cacheable read miss completes in the cycle after the last burst beat. An uncached read or any write completes in the cycle in which the bus acknowledges it. A mode change or an invalidate pulse empties the cache.

Top module: `cfg_dm_cache`

## Requirements
- R1: After reset every line is invalid, `bus_req` and `req_ready` are low, and the first cacheable read of any address misses.
- R2: A read that hits, presented while no bus cycle is pending, gets `req_ready` high in that same cycle, with the stored word on `resp_rdata`. There is no bus activity in that cycle or in the next one.
- R3: A cacheable read miss produces one burst (`bus_burst` high) of four single-word beats. The beat addresses start at the requested word and step by 4, wrapping inside the 16-byte line. The line is stored only after the fourth beat, and the held request then completes as a hit in the next cycle.
- R4: `cfg_mode` 00 caches instruction reads only, 01 caches data accesses only, and 10 or 11 caches both. A read that is not cacheable makes one non-burst bus read and completes in the cycle of `bus_ack`, with `resp_rdata` equal to `bus_rdata`.
- R5: In modes 00 and 01 the line index is address bits [12:4]. In split mode the index is {0 for instruction or 1 for data, address bits [11:4]}. The tag is always address bits [31:12].
- R6: Every write makes exactly one non-burst bus write, with `bus_addr` = `req_addr` and `bus_wdata` = `req_wdata`, and completes in the cycle of `bus_ack`. A write is a data access whatever `req_instr` says.
- R7: A write that hits a data line updates the stored word. A write miss allocates no line. A data write never changes an instruction line.
- R8: A pulse on `inv_all`, or any change of `cfg_mode`, clears every valid bit at the next clock edge.
- R9: If a clear event (R8) occurs while a burst fill is in progress, the fetched line is discarded and the held read misses again.
- R10: Once `bus_req` is high, it stays high with `bus_addr` and `bus_write` unchanged until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Cache organisation: 00 instruction, 01 data, 1x split |
| inv_all | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | Request is a write |
| req_instr | input | 1 | Request is an instruction fetch |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request completes this cycle |
| resp_rdata | output | 32 | Read data, valid with `req_ready` on reads |
| bus_req | output | 1 | Bus cycle requested |
| bus_write | output | 1 | Bus cycle is a write |
| bus_burst | output | 1 | Bus cycle is a line-fill beat |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus beat complete |
| bus_rdata | input | 32 | Bus read data |

## Verification
The reads used are:
- A cold read, which separates the reset state from the miss path.
- A read of the same line, which shows the hit path.
- A read starting mid-line, which exposes the wrap order of the fill addresses.
- Instruction and data reads of the same address in split mode, which show whether the two halves really are separate.
- Pairs of addresses that collide in one organisation but not in the other, which expose the index selection.

The writes are sent to hit lines, to missing lines and to lines held only by the instruction half, so that update, non-allocation and half separation can each be seen. Mode changes, plus an invalidate placed inside a running fill, tell a clean clear apart from a line installed after it.

Bus acknowledge latencies of zero, one and two cycles show whether the bus request is held correctly.

// File: rtl/cfg_dm_cache.sv
module cfg_dm_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 512,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              inv_all,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_instr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              bus_req,
  output logic              bus_write,
  output logic              bus_burst,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_LO = OFF_W + IDX_W - 1;
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam int WORDS  = LINES * LINE_WORDS;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WR, S_UNC} st_t;

  st_t               state_q;
  logic [WSEL_W-1:0] beat_q;
  logic              drop_q;
  logic [1:0]        mode_q;
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [WORDS];
  logic [DATA_W-1:0] fbuf_q [LINE_WORDS];

  logic              is_i, cacheable, hit, last_beat, clear, install, wr_upd;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel, fill_w;

  assign is_i      = req_instr && !req_write;
  assign cacheable = is_i ? (cfg_mode != 2'b01) : (cfg_mode != 2'b00);
  assign idx       = cfg_mode[1] ? {~is_i, req_addr[OFF_W+IDX_W-2:OFF_W]}
                                 : req_addr[OFF_W+IDX_W-1:OFF_W];
  assign tag       = req_addr[ADDR_W-1:TAG_LO];
  assign wsel      = req_addr[OFF_W-1:BYTE_W];
  assign hit       = cacheable && valid_q[idx] && (tag_q[idx] == tag);
  assign fill_w    = wsel + beat_q;
  assign last_beat = (beat_q == WSEL_W'(LINE_WORDS - 1));
  assign clear     = inv_all || (cfg_mode != mode_q);
  assign install   = (state_q == S_FILL) && bus_ack && last_beat && !drop_q && !clear;
  assign wr_upd    = (state_q == S_WR) && bus_ack && hit;

  assign bus_req    = (state_q != S_IDLE);
  assign bus_write  = (state_q == S_WR);
  assign bus_burst  = (state_q == S_FILL);
  assign bus_addr   = bus_burst ? {req_addr[ADDR_W-1:OFF_W], fill_w, {BYTE_W{1'b0}}} : req_addr;
  assign bus_wdata  = req_wdata;
  assign req_ready  = ((state_q == S_IDLE) && req_valid && !req_write && hit) ||
                      (((state_q == S_WR) || (state_q == S_UNC)) && bus_ack);
  assign resp_rdata = (state_q == S_UNC) ? bus_rdata : data_q[{idx, wsel}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      drop_q  <= 1'b0;
      mode_q  <= 2'b00;
      valid_q <= '0;
    end else begin
      mode_q <= cfg_mode;
      case (state_q)
        S_IDLE: if (req_valid) begin
          if (req_write) begin
            state_q <= S_WR;
          end else if (!hit) begin
            state_q <= cacheable ? S_FILL : S_UNC;
            beat_q  <= '0;
            drop_q  <= 1'b0;
          end
        end
        S_FILL: begin
          if (clear) drop_q <= 1'b1;
          if (bus_ack) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= S_IDLE;
          end
        end
        default: if (bus_ack) state_q <= S_IDLE;
      endcase
      if (clear) valid_q <= '0;
      else if (install) valid_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if ((state_q == S_FILL) && bus_ack) fbuf_q[fill_w] <= bus_rdata;
    if (install) begin
      tag_q[idx] <= tag;
      for (int w = 0; w < LINE_WORDS; w++)
        data_q[{idx, WSEL_W'(w)}] <= (WSEL_W'(w) == fill_w) ? bus_rdata : fbuf_q[WSEL_W'(w)];
    end
    if (wr_upd) data_q[{idx, wsel}] <= req_wdata;
  end
endmodule

// File: rtl/cfg_dm_cache_chk.sv
module cfg_dm_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_write,
  input logic              req_ready,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              bus_req,
  input logic              bus_write,
  input logic              bus_burst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_req && !req_ready);

  assert_hit_no_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_write && !bus_req |=> !bus_req);

  assert_fill_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst && bus_ack |=> !bus_burst ||
      (bus_addr[OFF_W-1:BYTE_W] == WSEL_W'($past(bus_addr[OFF_W-1:BYTE_W]) + 1'b1)));

  assert_fill_not_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst |-> !req_ready);

  assert_uncached_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_write && bus_req |-> !bus_burst && !bus_write && (resp_rdata == bus_rdata));

  assert_write_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_write |-> bus_ack && bus_write && !bus_burst);

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_write));
endmodule

bind cfg_dm_cache cfg_dm_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_ready(req_ready),
  .resp_rdata(resp_rdata), .bus_req(bus_req), .bus_write(bus_write),
  .bus_burst(bus_burst), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
);

// File: tb/sim_cfg_dm_cache.sv
module sim_cfg_dm_cache;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic [1:0]  cfg_mode = 2'b10;
  logic        inv_all = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_instr = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, bus_req, bus_write, bus_burst;
  logic [31:0] resp_rdata, bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  cfg_dm_cache u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .inv_all(inv_all),
    .req_valid(req_valid), .req_write(req_write), .req_instr(req_instr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_rdata(resp_rdata), .bus_req(bus_req), .bus_write(bus_write),
    .bus_burst(bus_burst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // external memory and reference model state
  logic [31:0] ext[int];
  bit          m_val[int];
  logic [19:0] m_tag[int];
  logic [31:0] m_dat[int];
  logic [31:0] m_fb[4];
  int          m_st = 0, m_beat = 0;
  bit          m_drop = 0;
  logic [1:0]  m_prev = 2'b00;
  int          lat = 1, wait_cnt = 0;
  int          g_fills = 0, g_kind = 0;
  bit          g_prev_burst = 0;

  function automatic logic [31:0] ext_rd(logic [31:0] a);
    int k = int'(a >> 2);
    if (ext.exists(k)) return ext[k];
    return {a[31:2], 2'b00} ^ 32'h5A3C_96E1;
  endfunction

  task automatic cycle(output bit rdy);
    logic [31:0] a;
    bit is_i, cach, hit, clr, ack, dr, exp_ready;
    int idx, w;
    #1;
    ack = bus_req && (wait_cnt >= lat);
    bus_ack = ack;
    bus_rdata = (ack && !bus_write) ? ext_rd(bus_addr) : 32'h0;
    #1;
    a    = req_addr;
    is_i = req_instr && !req_write;
    cach = is_i ? (cfg_mode != 2'b01) : (cfg_mode != 2'b00);
    idx  = cfg_mode[1] ? ((is_i ? 0 : 256) + int'(a[11:4])) : int'(a[12:4]);
    w    = int'(a[3:2]);
    hit  = cach && m_val.exists(idx) && (m_tag[idx] == a[31:12]);
    exp_ready = (m_st == 0 && req_valid && !req_write && hit) || ((m_st == 2 || m_st == 3) && ack);
    check("R2 req_ready", {31'b0, req_ready}, {31'b0, exp_ready});
    if (exp_ready && !req_write)
      check(m_st == 3 ? "R4 uncached data" : "R2 hit data", resp_rdata,
            m_st == 3 ? bus_rdata : m_dat[idx * 4 + w]);
    check("R10 bus_req", {31'b0, bus_req}, {31'b0, m_st != 0});
    if (m_st != 0) begin
      check("R6 bus_write", {31'b0, bus_write}, {31'b0, m_st == 2});
      check("R3 bus_burst", {31'b0, bus_burst}, {31'b0, m_st == 1});
      check(m_st == 1 ? "R3 wrap address" : "R6 bus_addr", bus_addr,
            m_st == 1 ? {a[31:4], 2'(w + m_beat), 2'b00} : a);
      if (m_st == 2) check("R6 bus_wdata", bus_wdata, req_wdata);
    end
    if (bus_burst && !g_prev_burst) g_fills++;
    g_prev_burst = bus_burst;
    if (bus_req) g_kind = bus_write ? 3 : (bus_burst ? 2 : 1);
    // advance model to the coming edge
    clr = inv_all || (cfg_mode != m_prev);
    m_prev = cfg_mode;
    case (m_st)
      0: if (req_valid) begin
        if (req_write) m_st = 2;
        else if (!hit) begin m_st = cach ? 1 : 3; m_beat = 0; m_drop = 0; end
      end
      1: begin
        dr = m_drop;
        if (clr) m_drop = 1;
        if (ack) begin
          m_fb[(w + m_beat) % 4] = bus_rdata;
          if (m_beat == 3) begin
            if (!dr && !clr) begin
              m_val[idx] = 1; m_tag[idx] = a[31:12];
              for (int k = 0; k < 4; k++) m_dat[idx * 4 + k] = m_fb[k];
            end
            m_st = 0;
          end else m_beat++;
        end
      end
      2: if (ack) begin
        if (hit) m_dat[idx * 4 + w] = req_wdata;
        m_st = 0;
      end
      default: if (ack) m_st = 0;
    endcase
    if (clr) m_val.delete();
    if (ack && bus_write) ext[int'(bus_addr >> 2)] = bus_wdata;
    if (bus_req && !ack) wait_cnt++; else wait_cnt = 0;
    rdy = req_ready;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    bit r;
    for (int i = 0; i < n; i++) cycle(r);
  endtask

  task automatic do_req(bit wr, bit ins, logic [31:0] a, logic [31:0] d, int exp_kind,
                        string tag, output logic [31:0] rd, input int inv_at = -1);
    bit rdy = 0;
    int n = 0;
    g_kind = 0; g_fills = 0;
    req_valid = 1; req_write = wr; req_instr = ins; req_addr = a; req_wdata = d;
    while (!rdy && n < 200) begin
      inv_all = (n == inv_at);
      rd = resp_rdata;
      cycle(rdy);
      n++;
    end
    req_valid = 0; inv_all = 0;
    check({tag, " completes"}, {31'b0, rdy}, 32'd1);
    check({tag, " bus kind"}, g_kind, exp_kind);
  endtask

  // the read data is sampled inside the completing cycle
  logic [31:0] last_rd;
  always @(posedge clk) if (req_ready && !req_write) last_rd <= resp_rdata;

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 bus_req after reset", {31'b0, bus_req}, 32'd0);
    check("R1 req_ready after reset", {31'b0, req_ready}, 32'd0);
    idle(2);
    // split mode
    do_req(0, 0, 32'h0000_1000, 0, 2, "R1 cold read misses", rd);
    do_req(0, 0, 32'h0000_1008, 0, 0, "R2 same line hit", rd);
    check("R2 hit value", last_rd, ext_rd(32'h0000_1008));
    lat = 2;
    do_req(0, 0, 32'h0000_2028, 0, 2, "R3 mid-line miss", rd);
    do_req(0, 0, 32'h0000_2024, 0, 0, "R3 line installed", rd);
    lat = 0;
    do_req(0, 1, 32'h0000_1000, 0, 2, "R5 instr half separate", rd);
    do_req(0, 0, 32'h0000_1000, 0, 0, "R5 data line kept", rd);
    do_req(0, 0, 32'h0000_3000, 0, 2, "R5 data conflict", rd);
    do_req(0, 0, 32'h0000_1000, 0, 2, "R5 data evicted", rd);
    lat = 1;
    do_req(1, 1, 32'h0000_2028, 32'hDEAD_BEEF, 3, "R6 write with instr flag", rd);
    do_req(0, 0, 32'h0000_2028, 0, 0, "R7 read after write hit", rd);
    check("R7 updated word", last_rd, 32'hDEAD_BEEF);
    do_req(1, 0, 32'h0000_1004, 32'h1111_2222, 3, "R6 write to data line", rd);
    do_req(0, 0, 32'h0000_1004, 0, 0, "R7 data hit after write", rd);
    check("R7 data word updated", last_rd, 32'h1111_2222);
    do_req(0, 1, 32'h0000_1004, 0, 0, "R7 instr line untouched", rd);
    check("R7 instr word stale", last_rd, 32'h0000_1004 ^ 32'h5A3C_96E1);
    do_req(1, 0, 32'h0000_5000, 32'h7777_0001, 3, "R6 write miss", rd);
    do_req(0, 0, 32'h0000_5000, 0, 2, "R7 write miss not allocated", rd);
    check("R7 memory written", last_rd, 32'h7777_0001);
    // instruction-only mode
    cfg_mode = 2'b00; idle(1);
    do_req(0, 0, 32'h0000_1000, 0, 1, "R4 data uncached", rd);
    check("R4 uncached value", last_rd, ext_rd(32'h0000_1000));
    do_req(0, 0, 32'h0000_1000, 0, 1, "R4 data uncached again", rd);
    do_req(0, 1, 32'h0000_1000, 0, 2, "R8 mode change cleared", rd);
    do_req(0, 1, 32'h0000_1000, 0, 0, "R4 instr cached", rd);
    // data-only mode
    cfg_mode = 2'b01; idle(1);
    do_req(0, 1, 32'h0000_1000, 0, 1, "R4 instr uncached", rd);
    do_req(0, 0, 32'h0000_1000, 0, 2, "R4 data miss", rd);
    do_req(0, 0, 32'h0000_2000, 0, 2, "R5 unified index", rd);
    do_req(0, 0, 32'h0000_1000, 0, 0, "R5 no conflict when unified", rd);
    do_req(0, 0, 32'h0000_3000, 0, 2, "R5 unified conflict", rd);
    do_req(0, 0, 32'h0000_1000, 0, 2, "R5 unified evicted", rd);
    inv_all = 1; idle(1); inv_all = 0;
    do_req(0, 0, 32'h0000_1000, 0, 2, "R8 invalidate cleared", rd);
    do_req(0, 0, 32'h0000_6008, 0, 2, "R9 clear during fill", rd, 3);
    check("R9 fill repeated", g_fills, 2);
    do_req(0, 0, 32'h0000_6004, 0, 0, "R9 second fill kept", rd);
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule